// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM. The host offers one access at a time through a valid/ready handshake carrying a 15-bit address, an 8-bit write byte and a direction flag. Read results come back on a one-clock strobe with the captured byte. On the memory side the controller drives the address, an active-low chip select, an active-low output enable and an active-low write enable. The bidirectional data pins are split into an outgoing byte, an incoming byte and a drive enable, so the tristate buffer sits at the chip top.

Every timing minimum of the memory is a nanosecond parameter. Each one is turned into a clock count by ceiling division with the clock period, so the same code serves any speed grade or clock rate. Output enable is held high for every write, so the plain write-pulse minimum is enough. After each read the controller waits out the memory's bus-release time before it lets its own drivers on. A level-sensitive standby input parks the memory deselected for data retention. On exit, a long recovery wait is enforced before the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset, chip select, output enable and write enable are all high (inactive), the drive enable is low and the read strobe is low.
- R2: A read holds chip select low, output enable low and write enable high, with the drive enable low for the whole time the memory may be driving. Control stays asserted for at least the address, chip-select and output-enable access times.
- R3: A read accepted at clock edge k returns its byte with the read strobe high for exactly one cycle, in the cycle after edge k+RD, where RD is the largest of the read access times and the read cycle time in clocks. RD is 7 at the default grade with a 10 ns clock.
- R4: A write holds write enable low for WP clocks, where WP is the largest of the pulse, address-valid, chip-select and data-setup minimums in clocks (6 by default). Throughout that time output enable is high, chip select is low and the drive enable is high.
- R5: Address and write data do not change while write enable is low. Write enable rises one clock before chip select, the drive enable, the address or the data change.
- R6: Address and write byte are registered when the request is accepted, and a read returns the byte most recently written to the same address.
- R7: After a read, ready stays low for the bus-release time in clocks (3 by default). The drive enable is never raised sooner than that after output enable rises.
- R8: A write keeps ready low for max(WP+1, write cycle time in clocks) cycles after acceptance. That is 7 by default.
- R9: While the controller is idle, a high standby input takes priority over a pending request. Chip select stays high, ready goes low, and the request is not started.
- R10: When standby drops, ready stays low until the recovery time in clocks has elapsed, then the pending request is served.
- R11: Ready is high only when the controller is idle, with all three memory strobes high and the drive enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_req | input | 1 | Level request for retention standby |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle strobe with read result |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 15 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte toward the data pins |
| mem_dq_in | input | 8 | Byte from the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
Two functions can land in the same cycle: a standby request and a host request, both arriving while the controller is idle. The bench raises both on the same falling edge. It then checks that chip select never falls and ready stays low for the whole standby. After release, it counts the cycles until ready returns and confirms the waiting read is then served with the right byte. A second overlap, a write issued straight after a read, is provoked by random back-to-back traffic. There, a timestamp monitor judges whether the drive enable rose inside the memory's bus-release window.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WPULSE,
      ST_WTAIL,
      ST_TURN,
      ST_SLEEP,
      ST_WAKE
   } sramc_state_t;

   // ceiling division of a nanosecond minimum by the clock period
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sramc_bus_regs.sv
module sramc_bus_regs #(
   parameter int AW = 15,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          grab,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_wdata,
   input  logic [DW-1:0] pin_rdata,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (take) begin
         addr_q  <= in_addr;
         wdata_q <= in_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= grab;
         if (grab) rd_data <= pin_rdata;
      end
   end

   // R6: captured address must not move between acceptance and the next acceptance
   a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(take) |-> $stable(addr_q));

   // R3: result strobe lasts a single cycle
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sramc_pkg::*;
#(
   parameter int AW        = 15,
   parameter int DW        = 8,
   parameter int CLK_NS    = 10,
   parameter int T_RC_NS   = 70,
   parameter int T_AA_NS   = 70,
   parameter int T_ACS_NS  = 70,
   parameter int T_AOE_NS  = 35,
   parameter int T_WC_NS   = 70,
   parameter int T_WP_NS   = 50,
   parameter int T_AW_NS   = 60,
   parameter int T_CW_NS   = 60,
   parameter int T_DW_NS   = 30,
   parameter int T_REL_NS  = 25,
   parameter int T_WAKE_NS = 5000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          standby_req,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   input  logic [DW-1:0] mem_dq_in,
   output logic          mem_dq_oe
);

   localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_ACS_NS, CLK_NS)),
                                         umax(umax(ns2cyc(T_AOE_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS)), 1));
   localparam int unsigned WP_CYC = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                         umax(umax(ns2cyc(T_CW_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)), 1));
   localparam int unsigned WC_CYC = ns2cyc(T_WC_NS, CLK_NS);
   localparam int unsigned WR_TAIL = (WC_CYC > WP_CYC + 1) ? WC_CYC - WP_CYC : 1;
   localparam int unsigned TA_CYC = umax(ns2cyc(T_REL_NS, CLK_NS), 1);
   localparam int unsigned WK_CYC = umax(ns2cyc(T_WAKE_NS, CLK_NS), 1);
   localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(umax(WR_TAIL, TA_CYC), WK_CYC));
   localparam int CNT_W = $clog2(MAX_CYC + 1);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_async_ctrl: address and data widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_async_ctrl: clock period must be at least 1 ns");
      end
      if (TA_CYC > 250) begin : g_bad_rel
         $error("sram_async_ctrl: bus release window too long for the checker counter");
      end
   endgenerate

   sramc_state_t state, nxt;
   logic         cs_n_q, oe_n_q, we_n_q, dq_oe_q;
   logic         cs_n_d, oe_n_d, we_n_d, dq_oe_d;
   logic         tm_load, tm_zero, take, grab;
   logic [CNT_W-1:0] tm_val;

   sramc_timer #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .zero     (tm_zero)
   );

   sramc_bus_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .grab      (grab),
      .in_addr   (req_addr),
      .in_wdata  (req_wdata),
      .pin_rdata (mem_dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   assign req_ready = (state == ST_IDLE) && !standby_req;

   always_comb begin
      nxt     = state;
      tm_load = 1'b0;
      tm_val  = '0;
      take    = 1'b0;
      grab    = 1'b0;
      cs_n_d  = cs_n_q;
      oe_n_d  = oe_n_q;
      we_n_d  = we_n_q;
      dq_oe_d = dq_oe_q;
      unique case (state)
         ST_IDLE: begin
            if (standby_req) begin
               nxt = ST_SLEEP;
            end else if (req_valid) begin
               take    = 1'b1;
               tm_load = 1'b1;
               cs_n_d  = 1'b0;
               if (req_write) begin
                  we_n_d  = 1'b0;
                  dq_oe_d = 1'b1;
                  tm_val  = CNT_W'(WP_CYC - 1);
                  nxt     = ST_WPULSE;
               end else begin
                  oe_n_d = 1'b0;
                  tm_val = CNT_W'(RD_CYC - 1);
                  nxt    = ST_READ;
               end
            end
         end
         ST_READ: begin
            if (tm_zero) begin
               grab    = 1'b1;
               cs_n_d  = 1'b1;
               oe_n_d  = 1'b1;
               tm_load = 1'b1;
               tm_val  = CNT_W'(TA_CYC - 1);
               nxt     = ST_TURN;
            end
         end
         ST_WPULSE: begin
            if (tm_zero) begin
               we_n_d  = 1'b1;
               tm_load = 1'b1;
               tm_val  = CNT_W'(WR_TAIL - 1);
               nxt     = ST_WTAIL;
            end
         end
         ST_WTAIL: begin
            if (tm_zero) begin
               cs_n_d  = 1'b1;
               dq_oe_d = 1'b0;
               nxt     = ST_IDLE;
            end
         end
         ST_TURN: begin
            if (tm_zero) nxt = ST_IDLE;
         end
         ST_SLEEP: begin
            if (!standby_req) begin
               tm_load = 1'b1;
               tm_val  = CNT_W'(WK_CYC - 1);
               nxt     = ST_WAKE;
            end
         end
         ST_WAKE: begin
            if (standby_req)  nxt = ST_SLEEP;
            else if (tm_zero) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cs_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
      end else begin
         state   <= nxt;
         cs_n_q  <= cs_n_d;
         oe_n_q  <= oe_n_d;
         we_n_q  <= we_n_d;
         dq_oe_q <= dq_oe_d;
      end
   end

   assign mem_cs_n  = cs_n_q;
   assign mem_oe_n  = oe_n_q;
   assign mem_we_n  = we_n_q;
   assign mem_dq_oe = dq_oe_q;

   // checker support: clocks since output enable was last low (saturating)
   logic [7:0] oe_idle_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   oe_idle_cnt <= 8'(TA_CYC);
      else if (!mem_oe_n)           oe_idle_cnt <= '0;
      else if (oe_idle_cnt != 8'hFF) oe_idle_cnt <= oe_idle_cnt + 1'b1;
   end

   // R2: no drive while the memory may be driving
   a_r2_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe && mem_we_n);

   // R4: write strobe only with output enable high, chip selected, drivers on
   a_r4_write_shape: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n && !mem_cs_n && mem_dq_oe);

   // R5: address and data frozen while write enable stays low
   a_r5_hold_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   // R5: write enable already high the cycle before drivers turn off
   a_r5_we_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_dq_oe) |-> $past(mem_we_n));

   // R7: drivers wait out the bus release window after a read
   a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_idle_cnt >= 8'(TA_CYC)));

   // R9: standby keeps the memory deselected and the host stalled
   a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP) |-> (mem_cs_n && !req_ready));

   // R11: ready only with every strobe inactive
   a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

   localparam int RD_LAT  = 7;
   localparam int WR_BUSY = 7;
   localparam int TA_WAIT = 3;
   localparam int WAKE    = 40;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, standby_req, req_valid, req_ready, req_write;
   logic [14:0] req_addr, mem_addr;
   logic [7:0]  req_wdata, rd_data, mem_dq_out, mem_dq_in;
   logic        rd_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bit [7:0] model_mem [int];
   bit [7:0] shadow    [int];

   sram_async_ctrl #(.CLK_NS(10), .T_WAKE_NS(400)) u_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .standby_req(standby_req),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
      .mem_dq_oe(mem_dq_oe)
   );

   function automatic logic [7:0] blank(input logic [14:0] a);
      return a[7:0] ^ a[14:7] ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // behavioural memory with timing monitors
   logic       model_drv;
   logic [7:0] model_q;
   time t_addr = 0, t_data = 0, t_we_fall = 0, t_cs_fall = 0, t_oe_fall = 0, t_release = 0;

   assign model_drv = !mem_cs_n && !mem_oe_n && mem_we_n;
   always @* model_q = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : blank(mem_addr);
   assign mem_dq_in = model_drv ? model_q : 8'h00;

   always @(mem_addr)          t_addr    = $time;
   always @(mem_dq_out)        t_data    = $time;
   always @(negedge mem_we_n)  t_we_fall = $time;
   always @(negedge mem_cs_n)  t_cs_fall = $time;
   always @(negedge mem_oe_n)  t_oe_fall = $time;

   always @(posedge mem_oe_n) begin
      if (rst_n) begin
         t_release = $time;
         check(($time - t_oe_fall) >= 35, "R2 oe access", $time - t_oe_fall, 35);
         check(($time - t_cs_fall) >= 70, "R2 cs access", $time - t_cs_fall, 70);
         check(($time - t_addr) >= 70, "R2 addr access", $time - t_addr, 70);
      end
   end

   always @(posedge mem_we_n) begin
      if (rst_n && !mem_cs_n) begin
         check(mem_oe_n == 1'b1, "R4 oe high in write", mem_oe_n, 1);
         check(mem_dq_oe == 1'b1, "R4 drive on at write end", mem_dq_oe, 1);
         check(($time - t_we_fall) >= 50, "R4 pulse width", $time - t_we_fall, 50);
         check(($time - t_cs_fall) >= 60, "R4 cs to end", $time - t_cs_fall, 60);
         check(($time - t_addr) >= 60, "R5 addr to end", $time - t_addr, 60);
         check(($time - t_data) >= 30, "R5 data setup", $time - t_data, 30);
         model_mem[int'(mem_addr)] = mem_dq_out;
      end
   end

   always @(posedge mem_dq_oe) begin
      if (rst_n) check(($time - t_release) >= 25, "R7 bus release", $time - t_release, 25);
   end

   always @(negedge clk) begin
      if (rst_n && model_drv && mem_dq_oe) check(1'b0, "R2 contention", 1, 0);
   end

   // host tasks
   task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [14:0] a, input logic [7:0] d);
      int n;
      issue(1'b1, a, d);
      shadow[int'(a)] = d;
      n = 0;
      while (!req_ready) begin @(negedge clk); n++; end
      check(n == WR_BUSY, "R8 write busy", n, WR_BUSY);
   endtask

   task automatic finish_read(input logic [14:0] a);
      int n, m;
      logic [7:0] exp;
      exp = shadow.exists(int'(a)) ? shadow[int'(a)] : blank(a);
      n = 0;
      while (!rd_valid) begin @(negedge clk); n++; end
      check(n == RD_LAT, "R3 read latency", n, RD_LAT);
      check(rd_data == exp, "R6 read data", rd_data, exp);
      m = 0;
      while (!req_ready) begin
         @(negedge clk); m++;
         if (m == 1) check(!rd_valid, "R3 strobe one cycle", rd_valid, 0);
      end
      check(m == TA_WAIT, "R7 turnaround wait", m, TA_WAIT);
   endtask

   task automatic do_read(input logic [14:0] a);
      issue(1'b0, a, 8'h00);
      finish_read(a);
   endtask

   logic [14:0] pool [8];

   initial begin
      int n;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; standby_req = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
      check(!mem_dq_oe && !rd_valid, "R1 drive and strobe low in reset", {mem_dq_oe, rd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R11 ready after reset", req_ready, 1);

      // directed corners
      do_read(15'h7FFF);
      do_write(15'h7FFF, 8'hA5);
      do_read(15'h7FFF);
      do_write(15'h0000, 8'h00);
      do_write(15'h0000, 8'hFF);
      do_read(15'h0000);
      do_write(15'h4000, 8'h3C);
      do_write(15'h4001, 8'hC3);
      do_read(15'h4000);
      do_read(15'h4001);

      // constrained random traffic
      foreach (pool[i]) pool[i] = 15'($urandom);
      for (int k = 0; k < 200; k++) begin
         logic [14:0] a;
         a = pool[$urandom % 8];
         if ($urandom % 2) do_write(a, 8'($urandom));
         else              do_read(a);
         repeat ($urandom % 3) @(negedge clk);
      end

      // standby raised together with a read request
      @(negedge clk);
      standby_req = 1'b1;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
      @(negedge clk);
      check(mem_cs_n, "R9 cs high in standby", mem_cs_n, 1);
      check(!req_ready, "R9 ready low in standby", req_ready, 0);
      repeat (6) @(negedge clk);
      check(mem_cs_n && mem_oe_n, "R9 request not started", {mem_cs_n, mem_oe_n}, 3);
      standby_req = 1'b0;
      n = 0;
      while (!req_ready) begin @(negedge clk); n++; end
      check(n == WAKE + 1, "R10 recovery wait", n, WAKE + 1);
      @(negedge clk);
      req_valid = 1'b0;
      finish_read(15'h7FFF);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R11 watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

endmodule